// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

This block is a 32-pin general-purpose I/O port. A plain register interface reads and writes its registers in single-cycle transfers. The output value and the output enable of every pin are held in registers, and the live pin levels can be read back. The pins are sampled through a two-flop synchronizer before anything else uses them.

Every pin has its own interrupt detector. A 2-bit trigger code selects one of four conditions: low level, high level, rising edge or falling edge. A separate per-pin bit selects triggering on both edges, and that bit takes precedence over the code. A detected event sets the pin's status bit, and software clears that bit by writing a one to it. The status bits that are enabled by the mask are combined into two request lines. One line serves the lower half of the port and the other serves the upper half, so each half can be routed to its own interrupt input.

Top module: `gpio_port`

## Requirements
- R1: A write to offset 0x00 sets the output value register, which drives `pad_o`, and a read of 0x00 returns that value. A write to offset 0x04 sets the direction register, which drives `pad_oe_o`, where 1 means output.
- R2: A read of offset 0x08 returns the pin levels after a two-flop synchronizer. Writes to 0x08 have no effect.
- R3: Offset 0x0C holds the 2-bit trigger codes for pins 0 to 15, and offset 0x10 holds them for pins 16 to 31. The field of pin p sits at bits [2*(p mod 16)+1 : 2*(p mod 16)]. The codes are 0 low level, 1 high level, 2 rising edge and 3 falling edge.
- R4: In a level mode, the status bit is set on every cycle that the synchronized level matches, including the cycle right after a clear.
- R5: In an edge mode, the status bit is set once when the synchronized pin value changes in the selected direction. The opposite transition sets nothing.
- R6: When bit p of the both-edge register at offset 0x20 is 1, pin p triggers on either transition, whatever its trigger code is.
- R7: The status register at offset 0x18 is write-one-to-clear, and zero bits in the write leave it unchanged. If a clear and an event land in the same cycle, the bit stays set.
- R8: The mask register sits at offset 0x14. `irq_lo_o` is the OR of status AND mask over pins 0 to 15, and `irq_hi_o` is the same over pins 16 to 31.
- R9: Reads take one cycle: `rdata_o` is loaded on the clock edge where `re_i` is high and holds otherwise. Offsets with no register read as zero, and writes to them are ignored.
- R10: Reset clears every register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| re_i | input | 1 | Register read strobe |
| addr_i | input | 6 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after `re_i` |
| pad_i | input | 32 | Pin levels from the pads |
| pad_o | output | 32 | Output value for the pins |
| pad_oe_o | output | 32 | Per-pin output enable |
| irq_lo_o | output | 1 | Request for pins 0 to 15 |
| irq_hi_o | output | 1 | Request for pins 16 to 31 |

## Verification
The bench gives each detector mode its own pin, and on that pin it drives a rising pulse and a falling pulse.

- A rising-mode pin latches on the first transition and not on the second.
- A falling-mode pin in the upper config register shows the opposite behaviour and confirms where its field sits.
- A pin with the both-edge bit set latches on both transitions even though its code says rising.
- A level-mode pin is cleared while its level is held, which separates a level detector from an edge detector.

Mask patterns that enable only one half of the port show which pins feed which request line.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned NPINS  = 32;
  localparam int unsigned HALF   = NPINS / 2;
  localparam int unsigned ADDR_W = 6;

  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'd0,
    TRIG_HIGH = 2'd1,
    TRIG_RISE = 2'd2,
    TRIG_FALL = 2'd3
  } trig_e;

  localparam addr_t OFS_DATA = 6'h00;
  localparam addr_t OFS_DIR  = 6'h04;
  localparam addr_t OFS_PAD  = 6'h08;
  localparam addr_t OFS_CFGL = 6'h0C;
  localparam addr_t OFS_CFGH = 6'h10;
  localparam addr_t OFS_MASK = 6'h14;
  localparam addr_t OFS_STAT = 6'h18;
  localparam addr_t OFS_BOTH = 6'h20;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
      prev_o <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
      prev_o <= q_o;
    end
  end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0]   cur_i,
  input  logic [W-1:0]   prev_i,
  input  logic [2*W-1:0] cfg_i,
  input  logic [W-1:0]   both_i,
  output logic [W-1:0]   evt_o
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic rise, fall, hit;
    trig_e code;
    assign rise = cur_i[i] & ~prev_i[i];
    assign fall = ~cur_i[i] & prev_i[i];
    assign code = trig_e'(cfg_i[2*i +: 2]);

    always_comb begin
      if (both_i[i]) hit = rise | fall;
      else begin
        unique case (code)
          TRIG_LOW:  hit = ~cur_i[i];
          TRIG_HIGH: hit = cur_i[i];
          TRIG_RISE: hit = rise;
          TRIG_FALL: hit = fall;
          default:   hit = 1'b0;
        endcase
      end
    end
    assign evt_o[i] = hit;
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [31:0]       pad_i,
  output logic [31:0]       pad_o,
  output logic [31:0]       pad_oe_o,
  output logic              irq_lo_o,
  output logic              irq_hi_o
);
  logic [NPINS-1:0] data_q, dir_q, mask_q, esel_q, status_q;
  logic [NPINS-1:0] cfg_lo_q, cfg_hi_q;
  logic [NPINS-1:0] sync_q, prev_q, evt, clr_mask;
  logic [31:0]      rd_mux;

  gpio_sync #(.W(NPINS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_i),
    .q_o   (sync_q),
    .prev_o(prev_q)
  );

  gpio_irq_detect #(.W(NPINS)) u_det (
    .cur_i (sync_q),
    .prev_i(prev_q),
    .cfg_i ({cfg_hi_q, cfg_lo_q}),
    .both_i(esel_q),
    .evt_o (evt)
  );

  assign clr_mask = (we_i && addr_i == OFS_STAT) ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q   <= '0;
      dir_q    <= '0;
      cfg_lo_q <= '0;
      cfg_hi_q <= '0;
      mask_q   <= '0;
      esel_q   <= '0;
      status_q <= '0;
    end else begin
      if (we_i) begin
        unique case (addr_i)
          OFS_DATA: data_q   <= wdata_i;
          OFS_DIR:  dir_q    <= wdata_i;
          OFS_CFGL: cfg_lo_q <= wdata_i;
          OFS_CFGH: cfg_hi_q <= wdata_i;
          OFS_MASK: mask_q   <= wdata_i;
          OFS_BOTH: esel_q   <= wdata_i;
          default: ;
        endcase
      end
      // a new event overrides a clear landing in the same cycle
      status_q <= (status_q & ~clr_mask) | evt;
    end
  end

  always_comb begin
    unique case (addr_i)
      OFS_DATA: rd_mux = data_q;
      OFS_DIR:  rd_mux = dir_q;
      OFS_PAD:  rd_mux = sync_q;
      OFS_CFGL: rd_mux = cfg_lo_q;
      OFS_CFGH: rd_mux = cfg_hi_q;
      OFS_MASK: rd_mux = mask_q;
      OFS_STAT: rd_mux = status_q;
      OFS_BOTH: rd_mux = esel_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= rd_mux;
  end

  assign pad_o    = data_q;
  assign pad_oe_o = dir_q;
  assign irq_lo_o = |(status_q[HALF-1:0] & mask_q[HALF-1:0]);
  assign irq_hi_o = |(status_q[NPINS-1:HALF] & mask_q[NPINS-1:HALF]);
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_irq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic              re_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic [31:0]       rdata_o,
  input logic [31:0]       pad_oe_o,
  input logic [NPINS-1:0]  status_q,
  input logic [NPINS-1:0]  mask_q,
  input logic [NPINS-1:0]  esel_q,
  input logic [NPINS-1:0]  evt,
  input logic [NPINS-1:0]  sync_q,
  input logic [NPINS-1:0]  prev_q,
  input logic              irq_lo_o,
  input logic              irq_hi_o
);
  logic [NPINS-1:0] clr_w;
  assign clr_w = (we_i && addr_i == OFS_STAT) ? wdata_i : '0;

  assert_status_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & $past(status_q & ~clr_w)) == $past(status_q & ~clr_w)));

  assert_status_src_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & ~$past(status_q | evt)) == '0));

  assert_irq_lo_mask_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q[HALF-1:0] == '0) |-> !irq_lo_o);

  assert_irq_hi_mask_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q[NPINS-1:HALF] == '0) |-> !irq_hi_o);

  assert_both_edge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((evt & esel_q & ~(sync_q ^ prev_q)) == '0));

  assert_dir_stable_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == OFS_DIR) |=> $stable(pad_oe_o));

  assert_rdata_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));
endmodule

bind gpio_port gpio_port_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .we_i    (we_i),
  .re_i    (re_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .pad_oe_o(pad_oe_o),
  .status_q(status_q),
  .mask_q  (mask_q),
  .esel_q  (esel_q),
  .evt     (evt),
  .sync_q  (sync_q),
  .prev_q  (prev_q),
  .irq_lo_o(irq_lo_o),
  .irq_hi_o(irq_hi_o)
);

// File: tb/gpio_port_test.sv
module gpio_port_test;
  import gpio_irq_pkg::*;

  logic clk = 1'b0, rst_ni = 1'b0, we = 1'b0, re = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0] wdata = '0, pad_in = '0;
  logic [31:0] rdata, pad_out, pad_oe;
  logic irq_lo, irq_hi;

  int total = 0, fails = 0;
  bit finished = 1'b0;

  typedef struct { logic [31:0] exp; string req; } exp_t;
  exp_t exp_q[$];
  logic rd_d = 1'b0;

  always #5 clk = ~clk;

  gpio_port uut (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we), .re_i(re), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pad_i(pad_in), .pad_o(pad_out),
    .pad_oe_o(pad_oe), .irq_lo_o(irq_lo), .irq_hi_o(irq_hi)
  );

  task automatic check(logic [31:0] act, logic [31:0] exp, string req);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // monitor: read data is compared one edge after the read strobe
  always @(posedge clk) rd_d <= re;
  always @(negedge clk) begin
    if (rd_d && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(rdata, e.exp, e.req);
    end
  end

  task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, logic [31:0] exp, string req);
    exp_t e;
    e.exp = exp; e.req = req;
    @(negedge clk); re = 1'b1; addr = a; exp_q.push_back(e);
    @(negedge clk); re = 1'b0;
    @(negedge clk);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R10 reset state
    check({30'd0, irq_hi, irq_lo}, 32'd0, "R10 irq");
    check(pad_out, 32'd0, "R10 pad_o");
    check(pad_oe, 32'd0, "R10 pad_oe");
    rd(OFS_DATA, 32'd0, "R10 data");
    rd(OFS_CFGH, 32'd0, "R10 cfg hi");
    rd(OFS_MASK, 32'd0, "R10 mask");
    rd(OFS_BOTH, 32'd0, "R10 both");

    // R1 data and direction
    wr(OFS_DATA, 32'hA5A5_0F0F);
    rd(OFS_DATA, 32'hA5A5_0F0F, "R1 data readback");
    check(pad_out, 32'hA5A5_0F0F, "R1 pad_o");
    wr(OFS_DIR, 32'hFFFF_0000);
    check(pad_oe, 32'hFFFF_0000, "R1 pad_oe");

    // R9 unused offsets
    wr(6'h24, 32'hDEAD_BEEF);
    rd(6'h24, 32'd0, "R9 unused read");
    rd(6'h02, 32'd0, "R9 misaligned read");

    // R2 pad status, writes ignored
    pad_in = 32'h1234_5678;
    settle();
    rd(OFS_PAD, 32'h1234_5678, "R2 pad levels");
    wr(OFS_PAD, 32'hFFFF_FFFF);
    rd(OFS_PAD, 32'h1234_5678, "R2 pad write ignored");

    // all pins rising; pin 17 falling (R3 field position in upper register)
    pad_in = 32'd0;
    settle();
    wr(OFS_CFGL, 32'hAAAA_AAAA);
    wr(OFS_CFGH, 32'hAAAA_AAAE);
    wr(OFS_STAT, 32'hFFFF_FFFF);
    settle();
    rd(OFS_STAT, 32'd0, "R7 clear all");

    // R5 rising on pin 0
    pad_in = 32'h1; settle();
    rd(OFS_STAT, 32'h1, "R5 rising sets");
    pad_in = 32'h0; settle();
    wr(OFS_STAT, 32'h1);
    rd(OFS_STAT, 32'h0, "R5 falling ignored in rising mode");

    // R3/R5 falling on pin 17
    pad_in = 32'h0002_0000; settle();
    rd(OFS_STAT, 32'h0, "R3 pin17 rise ignored");
    pad_in = 32'h0; settle();
    rd(OFS_STAT, 32'h0002_0000, "R3 pin17 fall sets");

    // R7 zero write leaves bits
    wr(OFS_STAT, 32'h0);
    rd(OFS_STAT, 32'h0002_0000, "R7 zero write keeps");

    // R8 split requests
    check({30'd0, irq_hi, irq_lo}, 32'd0, "R8 masked off");
    wr(OFS_MASK, 32'h0002_0000);
    check({30'd0, irq_hi, irq_lo}, 32'd2, "R8 upper request");
    wr(OFS_MASK, 32'h0000_FFFF);
    check({30'd0, irq_hi, irq_lo}, 32'd0, "R8 lower mask on upper pin");
    wr(OFS_STAT, 32'h0002_0000);
    rd(OFS_STAT, 32'h0, "R7 one clears");

    // R6 both edges on pin 3 (code says rising)
    wr(OFS_BOTH, 32'h8);
    pad_in = 32'h8; settle();
    wr(OFS_STAT, 32'h8);
    rd(OFS_STAT, 32'h0, "R6 cleared after rise");
    pad_in = 32'h0; settle();
    rd(OFS_STAT, 32'h8, "R6 fall sets");
    check({30'd0, irq_hi, irq_lo}, 32'd1, "R8 lower request");
    wr(OFS_STAT, 32'h8);

    // R4 high level on pin 5
    wr(OFS_CFGL, 32'hAAAA_A6AA);
    pad_in = 32'h20; settle();
    wr(OFS_STAT, 32'h20);
    rd(OFS_STAT, 32'h20, "R4 level re-sets after clear");
    pad_in = 32'h0; settle();
    wr(OFS_STAT, 32'h20);
    rd(OFS_STAT, 32'h0, "R4 level gone");

    // R4 low level on pin 0 (pad bit 0 already low)
    wr(OFS_CFGL, 32'hAAAA_A6A8);
    settle();
    rd(OFS_STAT, 32'h1, "R4 low level sets");

    finished = 1'b1;
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end
endmodule